// File: doc/BRIEF.md
# Loss-of-Lock Detector with Delayed Clear

This block sits beside a PLL phase detector. It decides whether the loop is locked by comparing how fast two clocks run: the reference clock that enters the phase detector, and the feedback clock that returns from the divider. Both clocks arrive as single-cycle edge strobes that are already synchronised to the system clock. The block counts a fixed number of reference strobes, called the window, and counts the feedback strobes that arrive in the same interval. The gap between the two counts, expressed in tenths of a part per million, goes to two comparators.

The set comparator raises the loss-of-lock flag. The clear comparator is tighter and lowers the flag. The band between the two thresholds gives hysteresis, so the flag does not chatter near the boundary. A programmable hold-off timer can delay the clear while the loop settles. A length of zero turns the delay off.

The block drives three outputs: a live flag, a sticky flag that firmware clears with a pulse, and an active-low pin that mirrors the live flag.

Top module: `lol_detect`

## Requirements
- R1: Each window closes on the WIN_REF-th reference strobe, with the feedback strobe of that same cycle counted in. The error is |feedback count − WIN_REF| × 10^7 / WIN_REF, in units of 0.1 ppm. With WIN_REF = 1000, one count of difference equals 10000 units.
- R2: When the error of a window is strictly greater than `set_thr`, `lol_live` is 1 two clock cycles after the edge that samples the closing reference strobe.
- R3: When `lol_live` is 1 and the error is less than or equal to `clr_thr`, the window is a clear window. A window whose error lies between the two thresholds leaves `lol_live` unchanged.
- R4: When `hold_len` is 0, a clear window drops `lol_live` at the same point where a set window would raise it.
- R5: When `hold_len` is N > 0, a clear window starts a timer, and `lol_live` stays 1 for N more clock cycles before it drops.
- R6: A set window that closes while the timer is running stops the timer, and `lol_live` stays 1.
- R7: Every set window drives `lol_sticky` to 1. A pulse on `sticky_clr` drives it to 0, and it then stays 0 until the next set window, even through clear windows.
- R8: When a `sticky_clr` pulse and a set window fall in the same cycle, `lol_sticky` ends up 1.
- R9: `lol_n` is always the inverse of `lol_live`.
- R10: After a synchronous reset, `lol_live` = 1, `lol_sticky` = 1 and `lol_n` = 0. The flag stays up until a clear window arrives.
- R11: When one error satisfies both thresholds (`clr_thr` ≥ `set_thr`), the set result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| fb_tick | input | 1 | One-cycle strobe per feedback clock edge |
| set_thr | input | THR_W | Error limit that asserts loss of lock, 0.1 ppm units |
| clr_thr | input | THR_W | Error limit that clears loss of lock, 0.1 ppm units |
| hold_len | input | TMR_W | Clear hold-off in clock cycles, 0 disables the timer |
| sticky_clr | input | 1 | Pulse that clears the sticky flag |
| lol_live | output | 1 | Current loss-of-lock state |
| lol_sticky | output | 1 | Latched loss-of-lock state |
| lol_n | output | 1 | Active-low loss-of-lock pin |

## Verification
The assertions assume that the two strobes are single-cycle pulses already synchronous to `clk`. They also assume that the thresholds and `hold_len` stay constant while a verdict is being applied, because the zero-length clear property reads `hold_len` in the cycle of the verdict. The stimulus meets these assumptions. Every strobe is driven on a falling clock edge. The thresholds and the timer length change only during idle gaps between windows. Each window is built from exactly WIN_REF reference strobes on alternate cycles, together with a chosen number of leading feedback strobes. This makes every error value an exact multiple of one count.

// File: rtl/lol_pkg.sv
package lol_pkg;
  // scale factor: one unit of error is 0.1 ppm, so a whole ratio is 10^7 units
  localparam logic [63:0] PPM_TENTHS = 64'd10_000_000;

  typedef struct packed {
    logic vld;      // one-cycle pulse per finished window
    logic set_hit;  // error above the set limit
    logic clr_hit;  // error at or below the clear limit
  } lol_verdict_t;
endpackage

// File: rtl/lol_window.sv
module lol_window #(
  parameter int WIN_REF = 1000,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             fb_tick,
  output logic             win_done,
  output logic [CNT_W-1:0] fb_total
);
  localparam int RW = (WIN_REF > 1) ? $clog2(WIN_REF) : 1;
  localparam logic [RW-1:0] REF_LAST = RW'(WIN_REF - 1);
  localparam logic [CNT_W-1:0] FB_MAX = {CNT_W{1'b1}};

  logic [RW-1:0]    ref_cnt;
  logic [CNT_W-1:0] fb_acc;
  logic [CNT_W-1:0] fb_next;
  logic             closing;

  always_comb begin
    closing = ref_tick && (ref_cnt == REF_LAST);
    // the feedback counter saturates, so a runaway feedback clock cannot wrap it
    if (fb_tick && (fb_acc != FB_MAX)) fb_next = fb_acc + 1'b1;
    else                               fb_next = fb_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt  <= '0;
      fb_acc   <= '0;
      fb_total <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= closing;
      if (closing) begin
        ref_cnt  <= '0;
        fb_acc   <= '0;
        fb_total <= fb_next;
      end else begin
        fb_acc <= fb_next;
        if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lol_compare.sv
module lol_compare
  import lol_pkg::*;
#(
  parameter int WIN_REF = 1000,
  parameter int CNT_W   = 11,
  parameter int THR_W   = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_done,
  input  logic [CNT_W-1:0] fb_total,
  input  logic [THR_W-1:0] set_thr,
  input  logic [THR_W-1:0] clr_thr,
  output lol_verdict_t     verdict
);
  localparam logic [CNT_W-1:0] REF_N = CNT_W'(WIN_REF);
  localparam logic [63:0] REF_N64 = 64'(WIN_REF);

  logic [CNT_W-1:0]       diff;
  logic [63:0]            err_scaled;
  logic [1:0][THR_W-1:0]  limit;
  logic [1:0][63:0]       limit_scaled;
  logic [1:0]             hit;

  always_comb begin
    if (fb_total >= REF_N) diff = fb_total - REF_N;
    else                   diff = REF_N - fb_total;
    // compare error*10^7 against limit*WIN_REF, which avoids a divider
    err_scaled = 64'(diff) * PPM_TENTHS;
    limit[0]   = set_thr;
    limit[1]   = clr_thr;
  end

  // index 0 is the set comparator (strictly above), index 1 the clear comparator (at or below)
  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign limit_scaled[g] = 64'(limit[g]) * REF_N64;
    if (g == 0) begin : g_set
      assign hit[g] = err_scaled > limit_scaled[g];
    end else begin : g_clr
      assign hit[g] = err_scaled <= limit_scaled[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict <= '0;
    end else begin
      verdict.vld     <= win_done;
      verdict.set_hit <= win_done && hit[0];
      verdict.clr_hit <= win_done && hit[1];
    end
  end
endmodule

// File: rtl/lol_status.sv
module lol_status
  import lol_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  lol_verdict_t     verdict,
  input  logic [TMR_W-1:0] hold_len,
  input  logic             sticky_clr,
  output logic             live,
  output logic             sticky,
  output logic             pin_n
);
  logic             run_q, run_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             live_d, sticky_d;
  logic             set_evt, clr_evt, expire;

  always_comb begin
    set_evt  = verdict.vld && verdict.set_hit;
    clr_evt  = verdict.vld && verdict.clr_hit && !verdict.set_hit;
    expire   = run_q && (({1'b0, cnt_q} + 1'b1) >= {1'b0, hold_len});
    live_d   = live;
    run_d    = run_q;
    cnt_d    = cnt_q;
    if (set_evt) begin
      live_d = 1'b1;
      run_d  = 1'b0;
      cnt_d  = '0;
    end else if (run_q) begin
      if (expire) begin
        live_d = 1'b0;
        run_d  = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (clr_evt && live) begin
      if (hold_len == '0) begin
        live_d = 1'b0;
      end else begin
        run_d = 1'b1;
        cnt_d = '0;
      end
    end
    // a new assertion wins over a clear request in the same cycle
    sticky_d = set_evt || (sticky && !sticky_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= 1'b1;
      sticky <= 1'b1;
      pin_n  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      live   <= live_d;
      sticky <= sticky_d;
      pin_n  <= !live_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/lol_detect.sv
module lol_detect
  import lol_pkg::*;
#(
  parameter int WIN_REF = 1000,
  parameter int THR_W   = 17,
  parameter int TMR_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             fb_tick,
  input  logic [THR_W-1:0] set_thr,
  input  logic [THR_W-1:0] clr_thr,
  input  logic [TMR_W-1:0] hold_len,
  input  logic             sticky_clr,
  output logic             lol_live,
  output logic             lol_sticky,
  output logic             lol_n
);
  localparam int CNT_W = $clog2(2 * WIN_REF + 1);

  logic             win_done;
  logic [CNT_W-1:0] fb_total;
  lol_verdict_t     verdict;
  logic             v_vld, v_set, v_clr;

  assign v_vld = verdict.vld;
  assign v_set = verdict.set_hit;
  assign v_clr = verdict.clr_hit;

  lol_window #(.WIN_REF(WIN_REF), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .win_done(win_done), .fb_total(fb_total)
  );

  lol_compare #(.WIN_REF(WIN_REF), .CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
    .clk(clk), .rst(rst), .win_done(win_done), .fb_total(fb_total),
    .set_thr(set_thr), .clr_thr(clr_thr), .verdict(verdict)
  );

  lol_status #(.TMR_W(TMR_W)) u_stat (
    .clk(clk), .rst(rst), .verdict(verdict), .hold_len(hold_len),
    .sticky_clr(sticky_clr), .live(lol_live), .sticky(lol_sticky), .pin_n(lol_n)
  );
endmodule

// File: rtl/lol_detect_chk.sv
module lol_detect_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             live,
  input logic             sticky,
  input logic             pin_n,
  input logic             vld,
  input logic             set_hit,
  input logic             clr_hit,
  input logic [TMR_W-1:0] hold_len
);
  always @(posedge clk) begin
    if (!rst) AST_PIN_INVERSE: assert (pin_n == !live); // R9
  end

  AST_SET_RAISES_LIVE: assert property (@(posedge clk) disable iff (rst)
    (vld && set_hit) |=> live); // R2

  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(live) |-> $past(vld && set_hit)); // R11

  AST_FALL_NOT_ON_SET: assert property (@(posedge clk) disable iff (rst)
    $fell(live) |-> !$past(vld && set_hit)); // R6

  AST_STICKY_ON_SET: assert property (@(posedge clk) disable iff (rst)
    (vld && set_hit) |=> sticky); // R8

  AST_STICKY_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky) |-> $past(vld && set_hit)); // R7

  AST_ZERO_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (vld && clr_hit && !set_hit && live && hold_len == '0) |=> !live); // R4
endmodule

bind lol_detect lol_detect_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .live(lol_live), .sticky(lol_sticky), .pin_n(lol_n),
  .vld(v_vld), .set_hit(v_set), .clr_hit(v_clr), .hold_len(hold_len)
);

// File: tb/sim_lol_detect.sv
`timescale 1ns/1ps
module sim_lol_detect;
  localparam int WIN = 1000;
  localparam int THR_W = 17;
  localparam int TMR_W = 16;
  localparam int NV = 11;
  // columns: feedback strobes per window, set limit, clear limit, expected live
  localparam int VEC [NV][4] = '{
    '{1000, 25000, 15000, 0},
    '{1002, 25000, 15000, 0},
    '{1003, 25000, 15000, 1},
    '{ 998, 25000, 15000, 1},
    '{ 999, 25000, 15000, 0},
    '{ 996, 25000, 15000, 1},
    '{1000, 25000, 15000, 0},
    '{1001,  5000,     0, 1},
    '{1000,  5000,     0, 0},
    '{1001,  5000, 20000, 1},
    '{1000, 25000, 15000, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, fb_tick = 1'b0, sticky_clr = 1'b0;
  logic [THR_W-1:0] set_thr = 17'd25000, clr_thr = 17'd15000;
  logic [TMR_W-1:0] hold_len = '0;
  logic lol_live, lol_sticky, lol_n;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  lol_detect #(.WIN_REF(WIN), .THR_W(THR_W), .TMR_W(TMR_W)) u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .set_thr(set_thr), .clr_thr(clr_thr), .hold_len(hold_len),
    .sticky_clr(sticky_clr), .lol_live(lol_live), .lol_sticky(lol_sticky), .lol_n(lol_n)
  );

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one window: reference strobe on odd cycles, feedback strobes first n cycles
  task automatic run_window(input int n, input bit clr_with_verdict);
    for (int i = 0; i < 2 * WIN; i++) begin
      @(negedge clk);
      ref_tick = (i % 2 == 1);
      fb_tick  = (i < n);
    end
    @(negedge clk);
    ref_tick = 1'b0;
    fb_tick  = 1'b0;
    @(negedge clk);
    sticky_clr = clr_with_verdict;
    @(negedge clk);
    sticky_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(lol_live, 1'b1, "R10 live after reset");
    check(lol_sticky, 1'b1, "R10 sticky after reset");
    check(lol_n, 1'b0, "R10 pin after reset");

    // table walk: R1 R2 R3 R4 R11 (hold_len = 0)
    for (int v = 0; v < NV; v++) begin
      set_thr = THR_W'(VEC[v][1]);
      clr_thr = THR_W'(VEC[v][2]);
      run_window(VEC[v][0], 1'b0);
      check(lol_live, VEC[v][3] != 0, $sformatf("R1/R2/R3/R4/R11 vector %0d", v));
      check(lol_n, VEC[v][3] == 0, $sformatf("R9 vector %0d", v));
    end
    check(lol_sticky, 1'b1, "R7 sticky held through clears");

    // sticky behaviour
    pulse_clear();
    check(lol_sticky, 1'b0, "R7 sticky cleared by pulse");
    run_window(1000, 1'b0);
    check(lol_sticky, 1'b0, "R7 clear window leaves sticky low");
    run_window(1005, 1'b1);
    check(lol_sticky, 1'b1, "R8 set wins over same-cycle clear");
    check(lol_live, 1'b1, "R2 set window raises live");
    pulse_clear();
    check(lol_sticky, 1'b0, "R7 clear while live");
    check(lol_live, 1'b1, "R7 live unaffected by sticky clear");

    // hold-off timer
    hold_len = 16'd3000;
    run_window(1000, 1'b0);
    check(lol_live, 1'b1, "R5 live held at timer start");
    idle(2990);
    check(lol_live, 1'b1, "R5 live held before timer end");
    idle(20);
    check(lol_live, 1'b0, "R5 live drops after timer");
    check(lol_n, 1'b1, "R9 pin after timer");

    // abort of a running timer
    run_window(1004, 1'b0);
    check(lol_live, 1'b1, "R6 live set before abort test");
    run_window(1000, 1'b0);
    run_window(1004, 1'b0);
    idle(1500);
    check(lol_live, 1'b1, "R6 timer aborted by set window");
    check(lol_sticky, 1'b1, "R7 sticky after new assertion");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule